// File: doc/BRIEF.md
# Four-Entry Instruction TLB Pseudo-LRU Tracker

This block holds the six-bit recency field of a four-entry, fully associative instruction translation buffer and picks which entry a refill should overwrite. Each bit of the field records the relative age of one pair of entries. A use of an entry, whether a lookup hit or a refill, sets or clears a fixed group of those bits. When the surrounding logic needs to copy a translation in from the larger unified buffer, it raises a victim request. One cycle later the block returns the index of the entry to replace. If the field holds a pattern that none of the four victim rules accept, the block raises an error flag in place of an index.

Software can write the whole field directly. The current field value is driven on an output so the enclosing control register can return it on a read. The caller treats a refill as a use: after receiving a victim index it strobes a use of that same index. The translation contents and the address comparison live outside this block.

Top module: `itlb_plru_tracker`

## Requirements
- R1: Synchronous active-high reset sets the field to 6'b000000 and drives victim_vld and victim_err low.
- R2: A use of entry 0 (use_idx=2'd0) clears field bits 5, 4 and 3 and leaves bits 2..0 unchanged.
- R3: A use of entry 1 (use_idx=2'd1) sets bit 5, clears bits 2 and 1, and leaves bits 4, 3 and 0 unchanged.
- R4: A use of entry 2 (use_idx=2'd2) sets bits 4 and 2, clears bit 0, and leaves bits 5, 3 and 1 unchanged.
- R5: A use of entry 3 (use_idx=2'd3) sets bits 3, 1 and 0 and leaves bits 5, 4 and 2 unchanged.
- R6: The victim rules are evaluated in the order entry 0, 1, 2, 3. Entry 0 is chosen when bits 5..3 are 111. Entry 1 is chosen when bit 5 is 0 and bits 2..1 are 11. Entry 2 is chosen when bit 4 is 0, bit 2 is 0 and bit 0 is 1. Entry 3 is chosen when bits 3, 1 and 0 are all 0.
- R7: A victim request asserted at a clock edge makes victim_vld high for the following cycle, with victim_idx decoded from the field value held before that edge; any use in the same cycle does not affect the returned index.
- R8: When no victim rule matches, the response has victim_err=1 and victim_idx=2'd0; otherwise victim_err=0.
- R9: A software write loads sw_data into the field on the next edge and overrides a use strobed in the same cycle.
- R10: With neither a use nor a write, the field holds its value; a victim request alone does not change it.
- R11: After uses of entries 0, 1, 2, 3 in that order starting from reset, the victim is entry 0; a further use of entry 0 makes entry 1 the victim.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| use_valid | input | 1 | Strobe: an entry was hit or refilled |
| use_idx | input | 2 | Index of the used entry |
| victim_req | input | 1 | Request a replacement choice |
| sw_wr | input | 1 | Software write strobe for the field |
| sw_data | input | 6 | Value written by software |
| lru_field | output | 6 | Current recency field |
| victim_vld | output | 1 | Registered response to victim_req |
| victim_idx | output | 2 | Entry chosen for replacement |
| victim_err | output | 1 | Field held no acceptable victim pattern |

## Verification
The bench checks each use mask from both an all-zero and an all-one field. These two starting points expose a swapped set or clear bit, or a touched bit that should have been left alone. It loads each victim pattern and two patterns that match no rule. A decoder with a wrong bit in its compare would return the wrong index or miss the error. A request and a use are issued in the same cycle: a design that decoded the updated field would answer with the new entry. A use is issued alongside a software write, and a design with the wrong precedence would leave the use's mask in the field. A full 0-1-2-3 use sequence confirms that the oldest entry is the one evicted.

// File: rtl/itlb_plru_pkg.sv
package itlb_plru_pkg;
  localparam int NUM_ENT = 4;
  localparam int IDX_W   = $clog2(NUM_ENT);
  localparam int AGE_W   = NUM_ENT * (NUM_ENT - 1) / 2;

  typedef logic [AGE_W-1:0] age_t;
  typedef logic [IDX_W-1:0] idx_t;

  // Bits forced high when an entry is used
  function automatic age_t use_set_mask(input int ent);
    case (ent)
      1:       use_set_mask = 6'b100000;
      2:       use_set_mask = 6'b010100;
      3:       use_set_mask = 6'b001011;
      default: use_set_mask = 6'b000000;
    endcase
  endfunction

  // Bits forced low when an entry is used
  function automatic age_t use_clr_mask(input int ent);
    case (ent)
      0:       use_clr_mask = 6'b111000;
      1:       use_clr_mask = 6'b000110;
      2:       use_clr_mask = 6'b000001;
      default: use_clr_mask = 6'b000000;
    endcase
  endfunction

  // Bits inspected by the victim rule of an entry
  function automatic age_t vic_care(input int ent);
    case (ent)
      0:       vic_care = 6'b111000;
      1:       vic_care = 6'b100110;
      2:       vic_care = 6'b010101;
      default: vic_care = 6'b001011;
    endcase
  endfunction

  // Required values of the inspected bits
  function automatic age_t vic_match(input int ent);
    case (ent)
      0:       vic_match = 6'b111000;
      1:       vic_match = 6'b000110;
      2:       vic_match = 6'b000001;
      default: vic_match = 6'b000000;
    endcase
  endfunction
endpackage

// File: rtl/itlb_plru_next.sv
module itlb_plru_next
  import itlb_plru_pkg::*;
(
  input  age_t cur_age,
  input  idx_t ent_sel,
  output age_t nxt_age
);
  age_t set_tab [NUM_ENT];
  age_t clr_tab [NUM_ENT];

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : g_mask
      assign set_tab[g] = use_set_mask(g);
      assign clr_tab[g] = use_clr_mask(g);
    end
  endgenerate

  always_comb begin
    nxt_age = (cur_age & ~clr_tab[ent_sel]) | set_tab[ent_sel];
  end
endmodule

// File: rtl/itlb_plru_pick.sv
module itlb_plru_pick
  import itlb_plru_pkg::*;
(
  input  age_t cur_age,
  output idx_t pick_idx,
  output logic pick_none
);
  logic [NUM_ENT-1:0] rule_hit;

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : g_rule
      assign rule_hit[g] = ((cur_age & vic_care(g)) == vic_match(g));
    end
  endgenerate

  // Lowest-numbered matching rule wins
  always_comb begin
    pick_idx = '0;
    for (int k = NUM_ENT - 1; k >= 0; k--) begin
      if (rule_hit[k]) pick_idx = idx_t'(k);
    end
    pick_none = ~|rule_hit;
  end
endmodule

// File: rtl/itlb_plru_tracker.sv
module itlb_plru_tracker
  import itlb_plru_pkg::*;
#(
  parameter logic [AGE_W-1:0] RST_AGE = '0
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             use_valid,
  input  logic [IDX_W-1:0] use_idx,
  input  logic             victim_req,
  input  logic             sw_wr,
  input  logic [AGE_W-1:0] sw_data,
  output logic [AGE_W-1:0] lru_field,
  output logic             victim_vld,
  output logic [IDX_W-1:0] victim_idx,
  output logic             victim_err
);
  age_t age_q;
  age_t age_upd;
  idx_t pick_idx;
  logic pick_none;

  itlb_plru_next u_next (
    .cur_age (age_q),
    .ent_sel (use_idx),
    .nxt_age (age_upd)
  );

  itlb_plru_pick u_pick (
    .cur_age   (age_q),
    .pick_idx  (pick_idx),
    .pick_none (pick_none)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= RST_AGE;
    end else if (sw_wr) begin
      age_q <= sw_data;
    end else if (use_valid) begin
      age_q <= age_upd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      victim_vld <= 1'b0;
      victim_idx <= '0;
      victim_err <= 1'b0;
    end else begin
      victim_vld <= victim_req;
      if (victim_req) begin
        victim_idx <= pick_none ? '0 : pick_idx;
        victim_err <= pick_none;
      end else begin
        victim_err <= 1'b0;
      end
    end
  end

  assign lru_field = age_q;
endmodule

// File: rtl/itlb_plru_checker.sv
module itlb_plru_checker
  import itlb_plru_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             use_valid,
  input logic [IDX_W-1:0] use_idx,
  input logic             victim_req,
  input logic             sw_wr,
  input logic [AGE_W-1:0] sw_data,
  input logic [AGE_W-1:0] lru_field,
  input logic             victim_vld,
  input logic [IDX_W-1:0] victim_idx,
  input logic             victim_err
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (lru_field == '0 && !victim_vld && !victim_err));

  // R2
  a_r2_use0_mask: assert property (@(posedge clk) disable iff (rst)
    (use_valid && use_idx == 2'd0 && !sw_wr) |=>
      (lru_field[5:3] == 3'b000 && lru_field[2:0] == $past(lru_field[2:0])));

  // R5
  a_r5_use3_mask: assert property (@(posedge clk) disable iff (rst)
    (use_valid && use_idx == 2'd3 && !sw_wr) |=>
      (lru_field[3] && lru_field[1] && lru_field[0] &&
       lru_field[5] == $past(lru_field[5]) && lru_field[4] == $past(lru_field[4]) &&
       lru_field[2] == $past(lru_field[2])));

  // R7
  a_r7_resp_follows_req: assert property (@(posedge clk) disable iff (rst)
    victim_req |=> victim_vld);

  a_r7_no_resp_without_req: assert property (@(posedge clk) disable iff (rst)
    !victim_req |=> !victim_vld);

  // R8
  a_r8_err_in_response: assert property (@(posedge clk) disable iff (rst)
    victim_err |-> (victim_vld && victim_idx == '0));

  // R9
  a_r9_write_wins: assert property (@(posedge clk) disable iff (rst)
    sw_wr |=> (lru_field == $past(sw_data)));

  // R10
  a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!sw_wr && !use_valid) |=> $stable(lru_field));
endmodule

bind itlb_plru_tracker itlb_plru_checker u_plru_chk (
  .clk        (clk),
  .rst        (rst),
  .use_valid  (use_valid),
  .use_idx    (use_idx),
  .victim_req (victim_req),
  .sw_wr      (sw_wr),
  .sw_data    (sw_data),
  .lru_field  (lru_field),
  .victim_vld (victim_vld),
  .victim_idx (victim_idx),
  .victim_err (victim_err)
);

// File: tb/tb_itlb_plru_tracker.sv
module tb_itlb_plru_tracker;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       use_valid;
  logic [1:0] use_idx;
  logic       victim_req;
  logic       sw_wr;
  logic [5:0] sw_data;
  logic [5:0] lru_field;
  logic       victim_vld;
  logic [1:0] victim_idx;
  logic       victim_err;

  int n_chk  = 0;
  int n_fail = 0;

  itlb_plru_tracker dut (
    .clk(clk), .rst(rst), .use_valid(use_valid), .use_idx(use_idx),
    .victim_req(victim_req), .sw_wr(sw_wr), .sw_data(sw_data),
    .lru_field(lru_field), .victim_vld(victim_vld),
    .victim_idx(victim_idx), .victim_err(victim_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    use_valid = 1'b0; victim_req = 1'b0; sw_wr = 1'b0;
  endtask

  task automatic do_write(input logic [5:0] v);
    sw_wr = 1'b1; sw_data = v; step();
  endtask

  task automatic do_use(input logic [1:0] i);
    use_valid = 1'b1; use_idx = i; step();
  endtask

  task automatic ask_victim(input string tag, input int exp_idx, input int exp_err);
    victim_req = 1'b1; step();
    check({tag, " vld"}, victim_vld, 1);
    check({tag, " idx"}, victim_idx, exp_idx);
    check({tag, " err"}, victim_err, exp_err);
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); step();
    rst = 1'b0;
    check("R1 field", lru_field, 6'h00);
    check("R1 vld", victim_vld, 0);
    check("R1 err", victim_err, 0);
    ask_victim("R1/R6 first victim", 3, 0);
  endtask

  task automatic t_use_masks();
    do_write(6'h3F); do_use(2'd0); check("R2 from ones", lru_field, 6'h07);
    do_write(6'h00); do_use(2'd0); check("R2 from zeros", lru_field, 6'h00);
    do_write(6'h3F); do_use(2'd1); check("R3 from ones", lru_field, 6'h39);
    do_write(6'h00); do_use(2'd1); check("R3 from zeros", lru_field, 6'h20);
    do_write(6'h3F); do_use(2'd2); check("R4 from ones", lru_field, 6'h3E);
    do_write(6'h00); do_use(2'd2); check("R4 from zeros", lru_field, 6'h14);
    do_write(6'h3F); do_use(2'd3); check("R5 from ones", lru_field, 6'h3F);
    do_write(6'h00); do_use(2'd3); check("R5 from zeros", lru_field, 6'h0B);
  endtask

  task automatic t_victim_rules();
    do_write(6'b111000); ask_victim("R6 rule0", 0, 0);
    do_write(6'b000110); ask_victim("R6 rule1", 1, 0);
    do_write(6'b000001); ask_victim("R6 rule2", 2, 0);
    do_write(6'b001011); ask_victim("R6 rule2 after use3", 2, 0);
    do_write(6'b000000); ask_victim("R6 rule3", 3, 0);
  endtask

  task automatic t_illegal();
    do_write(6'b000101); ask_victim("R8 illegal a", 0, 1);
    check("R10 field after request", lru_field, 6'h05);
    do_write(6'b101010); ask_victim("R8 illegal b", 0, 1);
    step();
    check("R7 vld drops", victim_vld, 0);
    check("R8 err drops", victim_err, 0);
  endtask

  task automatic t_same_cycle();
    do_write(6'h3F);
    victim_req = 1'b1; use_valid = 1'b1; use_idx = 2'd0; step();
    check("R7 old-state idx", victim_idx, 0);
    check("R2 use with request", lru_field, 6'h07);
    do_write(6'h00);
    sw_wr = 1'b1; sw_data = 6'h2A; use_valid = 1'b1; use_idx = 2'd3; step();
    check("R9 write beats use", lru_field, 6'h2A);
    step(); step();
    check("R10 idle hold", lru_field, 6'h2A);
  endtask

  task automatic t_sequence();
    rst = 1'b1; step(); rst = 1'b0;
    do_use(2'd0); do_use(2'd1); do_use(2'd2); do_use(2'd3);
    check("R11 field after 0123", lru_field, 6'h3F);
    ask_victim("R11 oldest is 0", 0, 0);
    do_use(2'd0);
    ask_victim("R11 next oldest is 1", 1, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; use_valid = 1'b0; use_idx = '0; victim_req = 1'b0;
    sw_wr = 1'b0; sw_data = '0;
    @(negedge clk);
    t_reset();
    t_use_masks();
    t_victim_rules();
    t_illegal();
    t_same_cycle();
    t_sequence();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule